// File: doc/BRIEF.md
# Packed Absolute Difference Summer

This unit takes two 64-bit words, each holding eight unsigned pixel bytes, and returns the sum of the eight absolute differences between matching bytes. This is the inner step of block-matching motion estimation. A caller presents both operands together with a one-cycle valid strobe. Two clock edges later the unit raises a result-valid strobe alongside a 64-bit word. That word holds the sum in its low bits and zeros above them.

Every lane forms its absolute difference as the larger byte minus the smaller one, so no signed intermediate is ever needed. The eight differences are captured in a register. A balanced adder tree then reduces them, and its output is captured in a second register. A new operand pair can enter on every clock, so one eight-pixel comparison completes per cycle. The register after the difference stage can be removed with a parameter. The default keeps it.

Top module: `sad_unit`

## Requirements
- R1: While reset is asserted and after its release until the first result, `outValid` is 0 and `result` is 0.
- R2: For an accepted pair, `result` equals the sum over lanes i = 0..7 of |A_i - B_i|. Lane i occupies bits 8i+7 down to 8i of each operand, and bytes are unsigned (0..255).
- R3: Bits 63 down to 11 of `result` are always zero, and the sum sits right-aligned starting at bit 0.
- R4: The largest possible sum, 2040 (every lane 0x00 against 0xFF), is returned exactly, without wrap.
- R5: Swapping the two operands gives the same result.
- R6: With the default configuration, `outValid` is high in the cycle after the second rising edge following an edge at which `inValid` was sampled high, and low otherwise.
- R7: Pairs presented on consecutive cycles produce results on consecutive cycles, in the order presented, one per clock.
- R8: While `outValid` is low, `result` keeps its last value, and operands presented with `inValid` low have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand pair valid strobe |
| opA | input | 64 | First packed operand, eight unsigned bytes |
| opB | input | 64 | Second packed operand, eight unsigned bytes |
| outValid | output | 1 | Result valid strobe |
| result | output | 64 | Right-aligned sum of absolute differences |

## Verification
The hardest case to reach from the ports is a full pipeline. In that case a new pair enters while the previous pair is still sitting in the difference register, and a lane mix-up or a stale stage only shows as a wrong value one slot later. The stimulus streams a fixed table and then a long run of pseudo-random words on back-to-back cycles. It then checks each output against the pair sent two cycles before. Byte patterns such as 0x80 against 0x7F, and opposite bytes in alternating lanes, target signed handling and the full-scale sum. Idle gaps carrying changing operands show that nothing leaks in while the strobe is low.

// File: rtl/sad_pkg.sv
package sad_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic diffLoad;  // capture lane differences
    logic sumLoad;   // capture reduced sum
  } sad_ctrl_t;
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] d
);
  // Larger minus smaller: unsigned, never negative
  always_comb begin
    if (a >= b) d = a - b;
    else        d = b - a;
  end
endmodule

// File: rtl/sad_control.sv
module sad_control
  import sad_pkg::*;
#(
  parameter bit DIFF_REG = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output sad_ctrl_t ctrl,
  output logic      outValid
);
  logic sumLoad;

  generate
    if (DIFF_REG) begin : g_twoStage
      logic stage1Vld;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage1Vld <= 1'b0;
        else       stage1Vld <= inValid;
      end
      assign sumLoad = stage1Vld;
    end else begin : g_oneStage
      assign sumLoad = inValid;
    end
  endgenerate

  always_comb begin
    ctrl.diffLoad = inValid;
    ctrl.sumLoad  = sumLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= sumLoad;
  end
endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int LANE_W   = 8,
  parameter int SUM_W    = 11,
  parameter bit DIFF_REG = 1'b1,
  localparam int WORD_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sad_ctrl_t         ctrl,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result
);
  logic [LANES-1:0][LANE_W-1:0] diffNow;
  logic [LANES-1:0][LANE_W-1:0] diffUse;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      sad_absdiff #(.LANE_W(LANE_W)) absdiff_i (
        .a(opA[i*LANE_W +: LANE_W]),
        .b(opB[i*LANE_W +: LANE_W]),
        .d(diffNow[i])
      );
    end

    if (DIFF_REG) begin : g_diffReg
      logic [LANES-1:0][LANE_W-1:0] diffQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              diffQ <= '0;
        else if (ctrl.diffLoad) diffQ <= diffNow;
      end
      assign diffUse = diffQ;
    end else begin : g_diffWire
      assign diffUse = diffNow;
    end
  endgenerate

  // Heap-ordered adder tree: node 1 is the root, leaves at LANES..2*LANES-1
  logic [SUM_W-1:0] node [1:2*LANES-1];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_leaf
      assign node[LANES+i] = {{(SUM_W-LANE_W){1'b0}}, diffUse[i]};
    end
    for (genvar n = 1; n < LANES; n++) begin : g_add
      assign node[n] = node[2*n] + node[2*n+1];
    end
  endgenerate

  logic [SUM_W-1:0] sumQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sumQ <= '0;
    else if (ctrl.sumLoad) sumQ <= node[1];
  end

  assign result = {{(WORD_W-SUM_W){1'b0}}, sumQ};
endmodule

// File: rtl/sad_unit.sv
module sad_unit
  import sad_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int LANE_W   = 8,
  parameter bit DIFF_REG = 1'b1,
  localparam int WORD_W  = LANES * LANE_W,
  localparam int SUM_W   = $clog2(LANES * ((1 << LANE_W) - 1) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] result
);
  sad_ctrl_t ctrl;

  sad_control #(.DIFF_REG(DIFF_REG)) control_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .ctrl(ctrl), .outValid(outValid)
  );

  sad_datapath #(
    .LANES(LANES), .LANE_W(LANE_W), .SUM_W(SUM_W), .DIFF_REG(DIFF_REG)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .opA(opA), .opB(opB), .result(result)
  );
endmodule

// File: rtl/sad_unit_checker.sv
module sad_unit_checker #(
  parameter int LANES    = 8,
  parameter int LANE_W   = 8,
  parameter bit DIFF_REG = 1'b1,
  localparam int WORD_W  = LANES * LANE_W,
  localparam int SUM_W   = $clog2(LANES * ((1 << LANE_W) - 1) + 1),
  localparam int MAX_SUM = LANES * ((1 << LANE_W) - 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic              outValid,
  input logic [WORD_W-1:0] result
);
  function automatic logic [WORD_W-1:0] refSad(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    int acc = 0;
    for (int i = 0; i < LANES; i++) begin
      int x = int'(a[i*LANE_W +: LANE_W]);
      int y = int'(b[i*LANE_W +: LANE_W]);
      acc += (x > y) ? x - y : y - x;
    end
    return WORD_W'(acc);
  endfunction

  // R3: upper bits stay zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    result[WORD_W-1:SUM_W] == '0);

  // R4: never beyond full-scale sum
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    result <= WORD_W'(MAX_SUM));

  // R8: result held while no new result
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(result));

  generate
    if (DIFF_REG) begin : g_two
      // R6: two-edge latency
      a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> ##1 outValid);
      a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> ##1 !outValid);
      // R2: value matches pair sent two edges earlier
      a_r2_sum: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> result == refSad($past(opA, 2), $past(opB, 2)));
    end else begin : g_one
      a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      a_r2_sum: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> result == refSad($past(opA), $past(opB)));
    end
  endgenerate
endmodule

bind sad_unit sad_unit_checker #(
  .LANES(LANES), .LANE_W(LANE_W), .DIFF_REG(DIFF_REG)
) checker_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .outValid(outValid), .result(result)
);

// File: tb/sad_unit_tb_top.sv
module sad_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sad_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result)
  );

  localparam int NV = 8;
  localparam logic [63:0] VEC_A [NV] = '{
    64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000,
    64'h0102030405060708, 64'h8000000000000000, 64'h00000000000000FF,
    64'h1010101010101010, 64'hFF00FF00FF00FF00 };
  localparam logic [63:0] VEC_B [NV] = '{
    64'h0000000000000000, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF,
    64'h0807060504030201, 64'h7F00000000000000, 64'h0000000000000001,
    64'h2020202020202020, 64'h00FF00FF00FF00FF };
  localparam logic [63:0] VEC_S [NV] = '{
    64'd0, 64'd2040, 64'd2040, 64'd32, 64'd1, 64'd254, 64'd128, 64'd2040 };

  function automatic logic [63:0] refSad(input logic [63:0] a, input logic [63:0] b);
    int acc = 0;
    for (int i = 0; i < 8; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      acc += (x > y) ? x - y : y - x;
    end
    return 64'(acc);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [63:0] expQ [64];
  logic [63:0] lfsr;
  logic [63:0] lastRes;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", 64'(outValid), 64'd0);
    check("R1 result in reset", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 outValid after release", 64'(outValid), 64'd0);
    check("R1 result after release", result, 64'd0);

    // R2 R4 R7: table streamed back-to-back, checked two slots later
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        check("R7 outValid stream", 64'(outValid), 64'd1);
        check($sformatf("R2 table vector %0d", i - 2), result, VEC_S[i-2]);
        check("R3 upper zero", {53'd0, result[63:11] != 53'd0}, 64'd0);
      end
      if (i < NV) begin
        inValid = 1'b1; opA = VEC_A[i]; opB = VEC_B[i];
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
    end
    check("R4 full-scale last vector", result, 64'd2040);

    // R5: operand swap
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) check($sformatf("R5 swapped vector %0d", i - 2), result, VEC_S[i-2]);
      if (i < NV) begin
        inValid = 1'b1; opA = VEC_B[i]; opB = VEC_A[i];
      end else inValid = 1'b0;
      @(negedge clk);
    end

    // R8: idle with changing operands
    lastRes = result;
    for (int i = 0; i < 4; i++) begin
      opA = 64'h1234567890ABCDEF ^ 64'(i); opB = ~opA;
      @(negedge clk);
      check("R8 outValid idle", 64'(outValid), 64'd0);
      check("R8 result held", result, lastRes);
    end

    // R6: single pulse latency
    inValid = 1'b1; opA = 64'h00000000000000FF; opB = 64'h0000000000000000;
    @(negedge clk);
    inValid = 1'b0; opA = '0; opB = 64'hFFFFFFFFFFFFFFFF;
    check("R6 not valid after one edge", 64'(outValid), 64'd0);
    @(negedge clk);
    check("R6 valid after two edges", 64'(outValid), 64'd1);
    check("R6 value", result, 64'd255);
    @(negedge clk);
    check("R6 single-cycle strobe", 64'(outValid), 64'd0);
    check("R8 stale operands ignored", result, 64'd255);

    // R7: pseudo-random back-to-back stream
    lfsr = 64'hACE1_2468_1357_BDF0;
    for (int i = 0; i < 42; i++) begin
      if (i >= 2) begin
        check("R7 random outValid", 64'(outValid), 64'd1);
        check($sformatf("R7 random vector %0d", i - 2), result, expQ[i-2]);
      end
      if (i < 40) begin
        inValid = 1'b1;
        opA = lfsr;
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        opB = lfsr;
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        expQ[i] = refSad(opA, opB);
      end else inValid = 1'b0;
      @(negedge clk);
    end

    // R6: valid, gap, valid
    inValid = 1'b1; opA = 64'h0000000000000003; opB = 64'h0000000000000000;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    inValid = 1'b1; opA = 64'h0500000000000000; opB = 64'h0000000000000000;
    check("R6 gap first result", result, 64'd3);
    @(negedge clk);
    inValid = 1'b0;
    check("R6 gap hole", 64'(outValid), 64'd0);
    @(negedge clk);
    check("R6 gap second valid", 64'(outValid), 64'd1);
    check("R2 top lane", result, 64'd5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule